// File: doc/BRIEF.md
# Chunk-level restore timing remapper

This block sits in a memory controller in front of the command scheduler. Each chip's bank is split into equal chunks, and every physical chunk has its own profiled restore time, measured in controller cycles. A logical chunk of the rank is made of one physical chunk from every chip, so it can only be served as fast as its slowest member. Without chunk-level timing, the single worst value applies to all of memory. The block holds a per-chip permutation that chooses which physical chunk of each chip serves each logical chunk. Slow chunks from different chips can then be grouped into the same logical chunks, and the other logical chunks become fast.

Configuration software writes the profiled timings one physical chunk at a time. It writes the permutation one whole chip row at a time. A row that names the same physical chunk twice is rejected and reported. After each accepted write the block computes the worst timing of every logical chunk and keeps it in a cache. For each access it then returns, one cycle later, the effective restore time and the physical chunk index to use in every chip.

Top module: `chunk_restore_remap`

## Requirements
- R1: After reset every physical chunk timing equals parameter TDEF (default 24), every chip maps logical chunk l to physical chunk l, cfg_err is low and rsp_valid is low.
- R2: rsp_valid is high in exactly the cycles that directly follow a cycle with lk_valid high, and the other response outputs belong to the lookup sampled at that edge.
- R3: rsp_phys carries, for each chip c, the physical chunk mapped to lk_chunk in chip c's row, in bits [c*CW +: CW], where CW = clog2(NCHUNK).
- R4: rsp_time equals the largest timing among the physical chunks that rsp_phys names across all chips.
- R5: cfg_time_we writes cfg_time as the timing of physical chunk cfg_chunk of chip cfg_chip. Lookups sampled two or more clock edges after the write's edge return the new value.
- R6: cfg_perm_we replaces chip cfg_chip's whole row when all entries are distinct. Entry l sits in cfg_perm[l*CW +: CW]. cfg_err stays low one cycle after an accepted row.
- R7: A row in which any two entries are equal is dropped, and that chip's mapping and all timings stay unchanged. cfg_err is high for exactly the one cycle after that write.
- R8: The rows of different chips are independent: writing one chip's row changes neither the mapping nor the physical chunks reported for any other chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_time_we | input | 1 | Write one physical chunk timing |
| cfg_perm_we | input | 1 | Write one chip's permutation row |
| cfg_chip | input | clog2(NCHIP) | Chip addressed by either write |
| cfg_chunk | input | CW | Physical chunk for a timing write |
| cfg_time | input | TW | Timing value in cycles |
| cfg_perm | input | NCHUNK*CW | Permutation row, entry l at [l*CW +: CW] |
| cfg_err | output | 1 | One-cycle pulse: row rejected as a duplicate |
| lk_valid | input | 1 | Lookup request |
| lk_chunk | input | CW | Logical chunk of the lookup |
| rsp_valid | output | 1 | Response valid |
| rsp_time | output | TW | Effective restore time of the logical chunk |
| rsp_phys | output | NCHIP*CW | Physical chunk per chip, chip c at [c*CW +: CW] |

## Verification
A stale timing cache shows up as a restore time that is too low or too high for a logical chunk. It appears on the second lookup after a write, and a lookup of each chunk at that point exposes it. A corrupted row, for example one kept after a duplicate was rejected, shows up at once in rsp_phys. Comparing the reported indices across all chunks of one chip shows the repeated index. A wrong reduction appears only once the chips differ in timing. The stimulus therefore gives each chip its own profile and remaps several chips before checking every logical chunk.

// File: rtl/chunk_restore_remap.sv
module chunk_restore_remap #(
  parameter int NCHIP  = 4,
  parameter int NCHUNK = 4,
  parameter int TW     = 6,
  parameter int TDEF   = 24
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_time_we,
  input  logic                            cfg_perm_we,
  input  logic [$clog2(NCHIP)-1:0]        cfg_chip,
  input  logic [$clog2(NCHUNK)-1:0]       cfg_chunk,
  input  logic [TW-1:0]                   cfg_time,
  input  logic [NCHUNK*$clog2(NCHUNK)-1:0] cfg_perm,
  output logic                            cfg_err,
  input  logic                            lk_valid,
  input  logic [$clog2(NCHUNK)-1:0]       lk_chunk,
  output logic                            rsp_valid,
  output logic [TW-1:0]                   rsp_time,
  output logic [NCHIP*$clog2(NCHUNK)-1:0] rsp_phys
);
  localparam int CW = $clog2(NCHUNK);

  logic [NCHIP-1:0][NCHUNK-1:0][TW-1:0] tm_q;
  logic [NCHIP-1:0][NCHUNK-1:0][CW-1:0] map_q;
  logic [NCHUNK-1:0][TW-1:0]            eff_q, eff_n;
  logic [NCHUNK-1:0][CW-1:0]            row;
  logic                                 dup, upd_q;

  assign row = cfg_perm;

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NCHUNK; i++)
      for (int j = i + 1; j < NCHUNK; j++)
        if (row[i] == row[j]) dup = 1'b1;
  end

  always_comb begin
    for (int l = 0; l < NCHUNK; l++) begin
      eff_n[l] = '0;
      for (int c = 0; c < NCHIP; c++)
        if (tm_q[c][map_q[c][l]] > eff_n[l]) eff_n[l] = tm_q[c][map_q[c][l]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCHIP; c++)
        for (int l = 0; l < NCHUNK; l++) begin
          tm_q[c][l]  <= TW'(TDEF);
          map_q[c][l] <= CW'(l);
        end
      for (int l = 0; l < NCHUNK; l++) eff_q[l] <= TW'(TDEF);
      upd_q     <= 1'b0;
      cfg_err   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_time  <= '0;
      rsp_phys  <= '0;
    end else begin
      if (cfg_time_we) tm_q[cfg_chip][cfg_chunk] <= cfg_time;
      if (cfg_perm_we && !dup) map_q[cfg_chip] <= row;
      cfg_err <= cfg_perm_we && dup;
      upd_q   <= cfg_time_we || (cfg_perm_we && !dup);
      if (upd_q) eff_q <= eff_n;
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_time <= eff_q[lk_chunk];
        for (int c = 0; c < NCHIP; c++) rsp_phys[c*CW +: CW] <= map_q[c][lk_chunk];
      end
    end
  end
endmodule

// File: rtl/chunk_restore_remap_chk.sv
module chunk_restore_remap_chk #(
  parameter int NCHIP  = 4,
  parameter int NCHUNK = 4,
  parameter int CW     = 2
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 lk_valid,
  input logic                                 rsp_valid,
  input logic                                 cfg_perm_we,
  input logic                                 cfg_err,
  input logic [NCHIP-1:0][NCHUNK-1:0][CW-1:0] map_q
);
  logic [NCHIP-1:0][NCHUNK-1:0] cov;

  always_comb begin
    cov = '0;
    for (int c = 0; c < NCHIP; c++)
      for (int l = 0; l < NCHUNK; l++) cov[c][map_q[c][l]] = 1'b1;
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid); // R2
  AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_perm_we)); // R7
  AST_REJECT_KEEPS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> map_q == $past(map_q)); // R7

  for (genvar c = 0; c < NCHIP; c++) begin : g_perm
    AST_ROW_BIJECTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      &cov[c]); // R6
  end
endmodule

bind chunk_restore_remap chunk_restore_remap_chk #(
  .NCHIP(NCHIP), .NCHUNK(NCHUNK), .CW($clog2(NCHUNK))
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
  .cfg_perm_we(cfg_perm_we), .cfg_err(cfg_err), .map_q(map_q)
);

// File: tb/chunk_restore_remap_bench.sv
module chunk_restore_remap_bench;
  localparam int NCHIP = 4, NCHUNK = 4, TW = 6, TDEF = 24, CW = 2;

  logic clk = 0, rst_n = 0;
  logic cfg_time_we = 0, cfg_perm_we = 0, lk_valid = 0;
  logic [1:0] cfg_chip = 0;
  logic [CW-1:0] cfg_chunk = 0, lk_chunk = 0;
  logic [TW-1:0] cfg_time = 0;
  logic [NCHUNK*CW-1:0] cfg_perm = 0;
  logic cfg_err, rsp_valid;
  logic [TW-1:0] rsp_time;
  logic [NCHIP*CW-1:0] rsp_phys;

  int checks = 0, errors = 0;
  int tm [NCHIP][NCHUNK];
  int mp [NCHIP][NCHUNK];

  always #2.5 clk = ~clk;

  chunk_restore_remap u_chunk_restore_remap (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic lookup_all(input string req);
    for (int l = 0; l < NCHUNK; l++) begin
      int worst = 0;
      @(negedge clk); lk_valid = 1; lk_chunk = CW'(l);
      @(negedge clk); lk_valid = 0;
      chk({req, " R2 valid"}, int'(rsp_valid), 1);
      for (int c = 0; c < NCHIP; c++) begin
        chk({req, " R3 phys"}, int'(rsp_phys[c*CW +: CW]), mp[c][l]);
        if (tm[c][mp[c][l]] > worst) worst = tm[c][mp[c][l]];
      end
      chk({req, " R4 time"}, int'(rsp_time), worst);
    end
    @(negedge clk);
    chk("R2 idle", int'(rsp_valid), 0);
  endtask

  task automatic write_time(input int c, input int p, input int v);
    @(negedge clk); cfg_time_we = 1; cfg_chip = 2'(c); cfg_chunk = CW'(p); cfg_time = TW'(v);
    @(negedge clk); cfg_time_we = 0;
    tm[c][p] = v;
    @(negedge clk);
  endtask

  task automatic write_perm(input int c, input int r0, input int r1, input int r2, input int r3,
                            input int exp_err);
    @(negedge clk); cfg_perm_we = 1; cfg_chip = 2'(c);
    cfg_perm = {CW'(r3), CW'(r2), CW'(r1), CW'(r0)};
    @(negedge clk); cfg_perm_we = 0;
    chk(exp_err ? "R7 err pulse" : "R6 no err", int'(cfg_err), exp_err);
    if (!exp_err) begin mp[c][0] = r0; mp[c][1] = r1; mp[c][2] = r2; mp[c][3] = r3; end
    @(negedge clk);
    chk("R7 err one cycle", int'(cfg_err), 0);
  endtask

  task automatic t_reset;
    for (int c = 0; c < NCHIP; c++)
      for (int l = 0; l < NCHUNK; l++) begin tm[c][l] = TDEF; mp[c][l] = l; end
    chk("R1 err", int'(cfg_err), 0);
    chk("R1 valid", int'(rsp_valid), 0);
    lookup_all("R1");
  endtask

  task automatic t_profile;
    for (int c = 0; c < NCHIP; c++)
      for (int p = 0; p < NCHUNK; p++) write_time(c, p, 14 + ((c * 7 + p * 5) % 11));
    write_time(2, 3, 24);
    lookup_all("R5");
  endtask

  task automatic t_remap;
    write_perm(0, 2, 0, 3, 1, 0);
    write_perm(3, 3, 2, 1, 0, 0);
    lookup_all("R6 R8");
    write_perm(1, 1, 1, 0, 2, 1);
    lookup_all("R7 kept");
    write_perm(2, 0, 3, 2, 3, 1);
    write_perm(1, 0, 3, 1, 2, 0);
    lookup_all("R8 R4");
  endtask

  task automatic t_late_timing;
    write_time(1, 3, 31);
    write_time(0, 0, 5);
    lookup_all("R5 late");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_profile();
    t_remap();
    t_late_timing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule